// File: doc/BRIEF.md
# Three-Wire Serial Clock-Calendar Target Interface

This block is the target side of a three-wire serial link that gives a host access to the registers of a real-time clock. The link has a chip-enable line, a serial clock and one data line that both sides drive in turn. The block runs on a fast system clock and passes every link input through a two-flop synchronizer. It finds serial clock edges by comparing the synchronized level with its value one cycle earlier.

A frame opens when chip enable rises. The host then shifts in a command byte, least significant bit first, and the block captures each bit on a rising serial clock edge. Command bit 7 must be set, or the frame is ignored. Command bit 0 gives the direction, and bits [5:1] give the register address.

- **Write frame:** the host sends a second byte. When that byte is complete, the block issues one write strobe on its parallel register port.
- **Read frame:** the block turns the data line around and returns the addressed register byte, least significant bit first. It launches one bit on each falling edge, starting with the falling edge of the 8th pulse.

Dropping chip enable ends any frame at once. The system clock must run at least 8 times faster than the serial clock. The block reacts to a pin edge within three system clock cycles.

Top module: `rtc3w_target`

## Requirements
- R1: After reset, `sdio_oe_o` is 0, `reg_we_o` is 0 and `reg_addr_o` is 0.
- R2: While `ce_i` is low, serial clock pulses and data-line activity produce no write strobe and never assert `sdio_oe_o`.
- R3: Command bits and write-data bits are taken from `sdio_i` on rising edges of `sclk_i`. The first bit of each byte is bit 0.
- R4: A write frame has command bit 0 equal to 0. It produces exactly one `reg_we_o` pulse, one system clock long, after the 16th rising edge. `reg_wdata_o` then holds the second byte.
- R5: A read frame has command bit 0 equal to 1. The block drives bit 0 of the addressed byte after the falling edge of the 8th pulse, and each following bit after each following falling edge, 8 bits in all. The byte is the value of `reg_rdata_i` at that 8th falling edge.
- R6: `sdio_oe_o` is high only in the read-data phase. It is low during the command byte and is released at the falling edge of the 16th pulse.
- R7: A command byte with bit 7 equal to 0 produces no write strobe, and `sdio_oe_o` stays low until `ce_i` falls. A later frame then works normally.
- R8: A low on `ce_i` at any point aborts the frame. A partly shifted write gives no strobe, and a read releases `sdio_oe_o` within 3 system clocks. The next frame after `ce_i` rises again is handled normally.
- R9: `reg_addr_o` shows command bits [5:1] from the end of the command byte and holds that value until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Link chip enable; a frame is active while high |
| sclk_i | input | 1 | Link serial clock |
| sdio_i | input | 1 | Level seen on the shared data pad |
| sdio_o | output | 1 | Value driven onto the data pad |
| sdio_oe_o | output | 1 | Pad output enable |
| reg_addr_o | output | 5 | Register address from command bits [5:1] |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Read data for the addressed register |

## Verification
A wrong bit count or direction decision shows at the ports within one frame:
- **Misplaced strobe:** the write strobe is missing, doubled, or carries a byte shifted by one position.
- **Early or late enable:** the pad enable rises during the command byte, or stays high past the 16th pulse.
- **Broken abort:** a state that ignores chip enable shows up as a strobe or a driven pad after chip enable drops, a few system clocks after the pin falls.

Read data is compared bit by bit at the end of each low half of the serial clock. A shift or load error therefore appears on the first wrong bit of the returned byte.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 5;
  localparam int ADDR_LSB = 1;
  localparam int DIR_BIT  = 0;
  localparam int CNT_W    = $clog2(BYTE_W);
  localparam int RDC_W    = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_WDATA = 3'd2,
    ST_RDATA = 3'd3,
    ST_HOLD  = 3'd4
  } rtc3w_state_e;
endpackage

// File: rtl/rtc3w_sync.sv
module rtc3w_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/rtc3w_rx_shift.sv
module rtc3w_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (clr_i)        data_d = '0;
    else if (shift_i) data_d = {bit_i, data_q[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_d;
  end

  assign data_o = data_q;
endmodule

// File: rtl/rtc3w_tx_shift.sv
module rtc3w_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         shift_i,
  output logic         bit_o
);
  logic [W-1:0] q, d;

  always_comb begin
    d = q;
    if (load_i)       d = load_data_i;
    else if (shift_i) d = {1'b0, q[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign bit_o = q[0];
endmodule

// File: rtl/rtc3w_target.sv
module rtc3w_target
  import rtc3w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_we_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam int EN_BIT = BYTE_W - 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [RDC_W-1:0] RD_END   = RDC_W'(BYTE_W);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // link input synchronizers and edge detection
  logic [2:0] pins_s;
  logic       ce_s, sclk_s, sd_s, sclk_prev_q, sclk_rise, sclk_fall;

  rtc3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .async_i({ce_i, sclk_i, sdio_i}),
    .sync_o (pins_s)
  );
  assign {ce_s, sclk_s, sd_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_s;
  end
  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign sclk_fall = ~sclk_s & sclk_prev_q;

  // frame state
  rtc3w_state_e      state_q, state_d;
  logic [CNT_W-1:0]  bit_cnt_q, bit_cnt_d;
  logic [RDC_W-1:0]  rd_cnt_q, rd_cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d, rx_data, cap_byte;
  logic              we_q, we_d, oe_q, oe_d;
  logic              rx_clr, rx_shift, tx_load, tx_shift;

  rtc3w_rx_shift #(.W(BYTE_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (rx_clr),
    .shift_i(rx_shift),
    .bit_i  (sd_s),
    .data_o (rx_data)
  );

  rtc3w_tx_shift #(.W(BYTE_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_i     (tx_load),
    .load_data_i(reg_rdata_i),
    .shift_i    (tx_shift),
    .bit_o      (sdio_o)
  );

  // byte as it stands once the current rising-edge bit is included
  assign cap_byte = {sd_s, rx_data[BYTE_W-1:1]};

  always_comb begin
    state_d   = state_q;
    bit_cnt_d = bit_cnt_q;
    rd_cnt_d  = rd_cnt_q;
    addr_d    = addr_q;
    wdata_d   = wdata_q;
    oe_d      = oe_q;
    we_d      = 1'b0;
    rx_clr    = 1'b0;
    rx_shift  = 1'b0;
    tx_load   = 1'b0;
    tx_shift  = 1'b0;
    if (!ce_s) begin
      state_d   = ST_IDLE;
      oe_d      = 1'b0;
      bit_cnt_d = '0;
      rd_cnt_d  = '0;
      rx_clr    = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d   = ST_CMD;
          bit_cnt_d = '0;
          rx_clr    = 1'b1;
        end
        ST_CMD: if (sclk_rise) begin
          rx_shift  = 1'b1;
          bit_cnt_d = bit_cnt_q + 1'b1;
          if (bit_cnt_q == LAST_BIT) begin
            bit_cnt_d = '0;
            if (!cap_byte[EN_BIT]) begin
              state_d = ST_HOLD;
            end else begin
              addr_d = cap_byte[ADDR_LSB +: ADDR_W];
              if (cap_byte[DIR_BIT]) begin
                state_d  = ST_RDATA;
                rd_cnt_d = '0;
              end else begin
                state_d = ST_WDATA;
              end
            end
          end
        end
        ST_WDATA: if (sclk_rise) begin
          rx_shift  = 1'b1;
          bit_cnt_d = bit_cnt_q + 1'b1;
          if (bit_cnt_q == LAST_BIT) begin
            we_d    = 1'b1;
            wdata_d = cap_byte;
            state_d = ST_HOLD;
          end
        end
        ST_RDATA: if (sclk_fall) begin
          if (rd_cnt_q == RD_END) begin
            oe_d    = 1'b0;
            state_d = ST_HOLD;
          end else begin
            if (rd_cnt_q == '0) begin
              tx_load = 1'b1;
              oe_d    = 1'b1;
            end else begin
              tx_shift = 1'b1;
            end
            rd_cnt_d = rd_cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      rd_cnt_q  <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      we_q      <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      bit_cnt_q <= bit_cnt_d;
      rd_cnt_q  <= rd_cnt_d;
      addr_q    <= addr_d;
      wdata_q   <= wdata_d;
      we_q      <= we_d;
      oe_q      <= oe_d;
    end
  end

  assign sdio_oe_o   = oe_q;
  assign reg_we_o    = we_q;
  assign reg_wdata_o = wdata_q;
  assign reg_addr_o  = addr_q;

  // R4: write strobe lasts a single cycle and only follows a finished write
  a_r4_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);
  a_r4_strobe_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> state_q == ST_HOLD);
  // R6: pad enable only in the read-data phase
  a_r6_oe_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> state_q == ST_RDATA);
  // R5: driven bit changes only after a falling serial clock edge
  a_r5_bit_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && !sclk_fall) |=> $stable(sdio_o));
  // R8: chip enable low forces idle with the pad released
  a_r8_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_s |=> (state_q == ST_IDLE && !oe_q && !we_q));
  // R2: idle never strobes nor drives
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!we_q && !oe_q));
endmodule

// File: tb/rtc3w_target_tb_top.sv
module rtc3w_target_tb_top;
  localparam int HP = 64;  // serial clock half period in system cycles

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0, sclk = 1'b0, mst_d = 1'b0;
  logic       sdio_o, sdio_oe;
  logic [4:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata, reg_rdata;
  logic       pad;

  int vectors = 0, miscompares = 0;
  int we_cnt = 0;
  logic [4:0] last_addr = '0;
  logic [7:0] last_data = '0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign pad = sdio_oe ? sdio_o : mst_d;

  function automatic logic [7:0] model(input logic [4:0] a);
    return {a, 3'b011} ^ 8'hA5;
  endfunction
  assign reg_rdata = model(reg_addr);

  rtc3w_target dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclk_i(sclk), .sdio_i(pad),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .reg_addr_o(reg_addr),
    .reg_we_o(reg_we), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  always @(negedge clk) if (reg_we) begin
    we_cnt++;
    last_addr = reg_addr;
    last_data = reg_wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial pulse; samples the pad outputs at the end of the low half
  task automatic pulse(input logic d, output logic s_oe, output logic s_d);
    mst_d = d;
    wait_clk(HP);
    s_oe = sdio_oe;
    s_d  = sdio_o;
    sclk = 1'b1;
    wait_clk(HP);
    sclk = 1'b0;
  endtask

  task automatic frame_open();
    ce = 1'b1;
    wait_clk(HP);
  endtask

  task automatic frame_close();
    wait_clk(HP);
    ce = 1'b0;
    wait_clk(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, input string req, output int oe_seen);
    logic so, sd;
    oe_seen = 0;
    for (int i = 0; i < 8; i++) begin
      pulse(b[i], so, sd);
      if (so) oe_seen++;
    end
  endtask

  task automatic t_reset();
    check("R1 oe after reset", sdio_oe, 0);
    check("R1 we after reset", reg_we, 0);
    check("R1 addr after reset", reg_addr, 0);
  endtask

  task automatic t_ce_low();
    logic so, sd;
    int oe_seen = 0;
    int w0 = we_cnt;
    ce = 1'b0;
    for (int i = 0; i < 16; i++) begin
      pulse(1'b1, so, sd);
      if (so) oe_seen++;
    end
    wait_clk(8);
    check("R2 no drive with ce low", oe_seen, 0);
    check("R2 no strobe with ce low", we_cnt - w0, 0);
  endtask

  task automatic t_write(input logic [4:0] a, input logic [7:0] d, input logic b6);
    int oe_seen, oe2;
    int w0 = we_cnt;
    frame_open();
    send_byte({1'b1, b6, a, 1'b0}, "R3", oe_seen);
    check("R9 addr after write command", reg_addr, a);
    send_byte(d, "R3", oe2);
    wait_clk(8);
    check("R6 no drive in write frame", oe_seen + oe2, 0);
    check("R4 single strobe per write", we_cnt - w0, 1);
    check("R4 strobe address", last_addr, a);
    check("R3 write data lsb first", last_data, d);
    frame_close();
  endtask

  task automatic t_read(input logic [4:0] a);
    int oe_seen;
    logic so, sd;
    logic [7:0] got = '0;
    int oe_cnt = 0;
    logic [7:0] exp = model(a);
    int w0 = we_cnt;
    frame_open();
    send_byte({1'b1, 1'b0, a, 1'b1}, "R6", oe_seen);
    check("R6 no drive during command", oe_seen, 0);
    check("R9 addr presented", reg_addr, a);
    for (int i = 0; i < 8; i++) begin
      pulse(1'b0, so, sd);
      got[i] = sd;
      if (so) oe_cnt++;
    end
    check("R6 drive during read bits", oe_cnt, 8);
    check("R5 read byte lsb first", got, exp);
    wait_clk(8);
    check("R6 released after 16th pulse", sdio_oe, 0);
    check("R5 no strobe on read", we_cnt - w0, 0);
    frame_close();
  endtask

  task automatic t_ignore(input logic dir);
    int o1, o2;
    int w0 = we_cnt;
    frame_open();
    send_byte({1'b0, 1'b0, 5'h0B, dir}, "R7", o1);
    send_byte(8'hFF, "R7", o2);
    wait_clk(8);
    check("R7 ignored command not driven", o1 + o2, 0);
    check("R7 ignored command no strobe", we_cnt - w0, 0);
    frame_close();
  endtask

  task automatic t_abort_write();
    logic so, sd;
    int oe_seen;
    int w0 = we_cnt;
    frame_open();
    send_byte({1'b1, 1'b0, 5'h07, 1'b0}, "R8", oe_seen);
    for (int i = 0; i < 4; i++) pulse(1'b1, so, sd);
    ce = 1'b0;
    wait_clk(HP);
    for (int i = 0; i < 4; i++) pulse(1'b1, so, sd);
    wait_clk(8);
    check("R8 aborted write no strobe", we_cnt - w0, 0);
  endtask

  task automatic t_abort_read();
    logic so, sd;
    int oe_seen;
    frame_open();
    send_byte({1'b1, 1'b0, 5'h15, 1'b1}, "R8", oe_seen);
    for (int i = 0; i < 3; i++) pulse(1'b0, so, sd);
    wait_clk(4);
    check("R8 driving before abort", sdio_oe, 1);
    ce = 1'b0;
    wait_clk(4);
    check("R8 released within 3 clocks of ce low", sdio_oe, 0);
    wait_clk(HP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_ce_low();
    t_write(5'h00, 8'h5A, 1'b0);
    t_write(5'h1F, 8'h81, 1'b1);
    t_read(5'h03);
    t_read(5'h1C);
    t_ignore(1'b1);
    t_read(5'h0B);
    t_ignore(1'b0);
    t_abort_write();
    t_write(5'h07, 8'hC3, 1'b0);
    t_abort_read();
    t_read(5'h15);
    report();
    $finish;
  end
endmodule